// File: doc/BRIEF.md
# Core Clock Governor with Automatic Wake Switchback

This block produces the core clock enable for a processor. It runs in the high-frequency system clock domain and also takes a once-per-period strobe from a 32,768 Hz low-frequency source, already synchronised into that domain. Software picks the operating point with a low-power enable bit and a 2-bit divide code. The low-power bit clear gives a full-speed divide of 1, 2, 4 or 8. The low-power bit set gives either divide-by-256 of the fast clock, or the slow clock directly.

When a low-power setting is in force and the wake-switchback enable is set, any strobe on the event vector sends the core back to the divide code it used just before it entered low power. The event strobes are already qualified by the peripherals: interrupt edges, serial receive or transmit activity, SPI or I2C starts, alarms, supply monitor, conversion start and debug entry. Both the return and each software write restart the divide counter. The block also drives the high-frequency oscillator enable. That enable is released only when the core runs from the slow clock and neither switchback nor the DSP core needs the fast clock.

The controller has three states:
- `ST_FULL` (full speed, low-power bit clear).
- `ST_PMM_DIV` (low power, divide by 256; codes 00, 01 and 10).
- `ST_PMM_LF` (low power, slow clock direct; code 11).

Transitions:
- A software write with the low-power bit clear goes to `ST_FULL`.
- A software write with the bit set goes to `ST_PMM_DIV` or `ST_PMM_LF`, according to the code.
- A wake event in either low-power state, with switchback armed, goes back to `ST_FULL` with the saved code.
- In every other case the state holds.

Top module: `core_clk_gov`

## Requirements
- R1: After reset the block is at full speed with code 00: `pmm_active`=0, `cur_cd`=00, `swb_flag`=0, `hf_osc_en`=1, and `core_ce` is high on every cycle.
- R2: At full speed, codes 00, 01, 10 and 11 give one `core_ce` pulse every 1, 2, 4 and 8 cycles respectively.
- R3: In low power with code 00, or with either reserved code 01 or 10, there is one `core_ce` pulse every 256 cycles.
- R4: In low power with code 11, `core_ce` follows `lf_tick`, giving one pulse per slow-clock strobe and no other pulses.
- R5: Every setting load (a software write or a switchback) restarts the counter, so the first pulse at divide N comes in the N-th cycle after the load edge.
- R6: A write that moves the block from full speed into low power saves the full-speed code. Later writes made while in low power leave the saved code unchanged.
- R7: In a low-power state, with `swb_en`=1 and any `evt` bit high, the next cycle is at full speed with the saved code and with `swb_flag`=1.
- R8: Events have no effect when `swb_en`=0 or when the block is already at full speed.
- R9: A software write in the same cycle as a wake event takes priority, and no switchback occurs.
- R10: `swb_flag` stays set until the next software write, which clears it.
- R11: `hf_osc_en` is 0 only in the slow-clock state with `swb_en`=0 and `dsp_active`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency system clock |
| rst_n | input | 1 | Active-low reset |
| lf_tick | input | 1 | One-cycle strobe per 32,768 Hz period |
| cfg_wr | input | 1 | Software write strobe for the setting |
| cfg_pmme | input | 1 | Low-power enable bit being written |
| cfg_cd | input | 2 | Divide code being written |
| swb_en | input | 1 | Wake switchback enable |
| evt | input | N_EVT | Qualified wake event strobes |
| dsp_active | input | 1 | DSP core running, needs the fast clock |
| core_ce | output | 1 | Core clock enable |
| hf_osc_en | output | 1 | High-frequency oscillator enable |
| pmm_active | output | 1 | Low-power setting in force |
| cur_cd | output | 2 | Divide code in force |
| swb_flag | output | 1 | A switchback has occurred |

## Verification
Writes and wake events act at the next clock edge. The bench therefore drives each stimulus for one cycle from a falling edge and reads the state outputs at the following falling edge. `core_ce` and `hf_osc_en` are combinational from the registered state, so they are read in the same cycle as that state. The first pulse after a load is expected N falling edges after the load edge. The bench counts the cycles up to that pulse and compares the count with N, then counts pulses over a fixed window to confirm the rate.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
    typedef enum logic [1:0] {
        ST_FULL    = 2'd0,
        ST_PMM_DIV = 2'd1,
        ST_PMM_LF  = 2'd2
    } ckdiv_state_e;

    localparam logic [1:0] CD_LF = 2'b11;
endpackage

// File: rtl/ckdiv_wake.sv
module ckdiv_wake #(
    parameter int N_EVT = 12
) (
    input  logic             swb_en,
    input  logic [N_EVT-1:0] evt,
    output logic             wake
);
    logic [N_EVT-1:0] seen;

    // Per-line gating by the arm bit, then an OR reduction.
    for (genvar g = 0; g < N_EVT; g++) begin : g_line
        assign seen[g] = evt[g] & swb_en;
    end

    assign wake = |seen;
endmodule

// File: rtl/ckdiv_fsm.sv
module ckdiv_fsm
    import ckdiv_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic         cfg_pmme,
    input  logic [1:0]   cfg_cd,
    input  logic         wake,
    input  logic         swb_en,
    input  logic         dsp_active,
    output ckdiv_state_e state,
    output logic [1:0]   cd,
    output logic [1:0]   shadow_cd,
    output logic         flag,
    output logic         load,
    output logic         hf_osc_en
);
    ckdiv_state_e state_q, state_d;
    logic [1:0]   cd_q, cd_d, shd_q, shd_d;
    logic         flag_q, flag_d;

    // Next-state logic; a software write outranks a wake event.
    always_comb begin
        state_d = state_q;
        cd_d    = cd_q;
        shd_d   = shd_q;
        flag_d  = flag_q;
        load    = 1'b0;
        if (cfg_wr) begin
            load   = 1'b1;
            flag_d = 1'b0;
            cd_d   = cfg_cd;
            if (cfg_pmme) begin
                state_d = (cfg_cd == CD_LF) ? ST_PMM_LF : ST_PMM_DIV;
                if (state_q == ST_FULL) begin
                    shd_d = cd_q;
                end
            end else begin
                state_d = ST_FULL;
            end
        end else begin
            unique case (state_q)
                ST_FULL: begin
                end
                ST_PMM_DIV, ST_PMM_LF: begin
                    if (wake) begin
                        state_d = ST_FULL;
                        cd_d    = shd_q;
                        flag_d  = 1'b1;
                        load    = 1'b1;
                    end
                end
                default: state_d = ST_FULL;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
            cd_q    <= 2'b00;
            shd_q   <= 2'b00;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cd_q    <= cd_d;
            shd_q   <= shd_d;
            flag_q  <= flag_d;
        end
    end

    // Outputs.
    always_comb begin
        state     = state_q;
        cd        = cd_q;
        shadow_cd = shd_q;
        flag      = flag_q;
        hf_osc_en = (state_q != ST_PMM_LF) | swb_en | dsp_active;
    end
endmodule

// File: rtl/ckdiv_count.sv
module ckdiv_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             lf_mode,
    input  logic             lf_tick,
    input  logic [CNT_W-1:0] term,
    output logic             ce
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || lf_mode || cnt_q >= term) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ce = lf_mode ? lf_tick : (cnt_q == term);
endmodule

// File: rtl/core_clk_gov.sv
module core_clk_gov
    import ckdiv_pkg::*;
#(
    parameter int N_EVT = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lf_tick,
    input  logic             cfg_wr,
    input  logic             cfg_pmme,
    input  logic [1:0]       cfg_cd,
    input  logic             swb_en,
    input  logic [N_EVT-1:0] evt,
    input  logic             dsp_active,
    output logic             core_ce,
    output logic             hf_osc_en,
    output logic             pmm_active,
    output logic [1:0]       cur_cd,
    output logic             swb_flag
);
    localparam logic [CNT_W-1:0] TERM_PMM = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    ckdiv_state_e     state;
    logic [1:0]       shadow_cd;
    logic             wake, load;
    logic [CNT_W-1:0] term;

    ckdiv_wake #(.N_EVT(N_EVT)) u_wake (
        .swb_en (swb_en),
        .evt    (evt),
        .wake   (wake)
    );

    ckdiv_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_pmme   (cfg_pmme),
        .cfg_cd     (cfg_cd),
        .wake       (wake),
        .swb_en     (swb_en),
        .dsp_active (dsp_active),
        .state      (state),
        .cd         (cur_cd),
        .shadow_cd  (shadow_cd),
        .flag       (swb_flag),
        .load       (load),
        .hf_osc_en  (hf_osc_en)
    );

    // Terminal count: (2^code)-1 at full speed, all ones in the divided low-power state.
    always_comb begin
        if (state == ST_FULL) begin
            term = (ONE << cur_cd) - ONE;
        end else begin
            term = TERM_PMM;
        end
    end

    ckdiv_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .lf_mode (state == ST_PMM_LF),
        .lf_tick (lf_tick),
        .term    (term),
        .ce      (core_ce)
    );

    assign pmm_active = (state != ST_FULL);
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk #(
    parameter int N_EVT = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lf_tick,
    input logic             cfg_wr,
    input logic             cfg_pmme,
    input logic [1:0]       cfg_cd,
    input logic             swb_en,
    input logic [N_EVT-1:0] evt,
    input logic             dsp_active,
    input logic             core_ce,
    input logic             hf_osc_en,
    input logic             pmm_active,
    input logic [1:0]       cur_cd,
    input logic             swb_flag,
    input logic [1:0]       shadow_cd
);
    p_full_every_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pmm_active && cur_cd == 2'b00) |-> core_ce);

    p_lf_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pmm_active && cur_cd == 2'b11) |-> (core_ce == lf_tick));

    p_shadow_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pmm_active |=> (shadow_cd == $past(shadow_cd)));

    p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pmm_active && swb_en && (|evt) && !cfg_wr)
        |=> (!pmm_active && swb_flag && cur_cd == $past(shadow_cd)));

    p_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pmm_active && !swb_en && !cfg_wr) |=> pmm_active);

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (pmm_active == $past(cfg_pmme) && cur_cd == $past(cfg_cd)));

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (swb_flag && !cfg_wr) |=> swb_flag);

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !swb_flag);

    p_osc_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hf_osc_en |-> (pmm_active && cur_cd == 2'b11 && !swb_en && !dsp_active));
endmodule

bind core_clk_gov ckdiv_chk #(.N_EVT(N_EVT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lf_tick    (lf_tick),
    .cfg_wr     (cfg_wr),
    .cfg_pmme   (cfg_pmme),
    .cfg_cd     (cfg_cd),
    .swb_en     (swb_en),
    .evt        (evt),
    .dsp_active (dsp_active),
    .core_ce    (core_ce),
    .hf_osc_en  (hf_osc_en),
    .pmm_active (pmm_active),
    .cur_cd     (cur_cd),
    .swb_flag   (swb_flag),
    .shadow_cd  (shadow_cd)
);

// File: tb/sim_core_clk_gov.sv
module sim_core_clk_gov;
    localparam int  N_EVT  = 12;
    localparam time T_CLK  = 10ns;
    localparam int  WD_MAX = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lf_tick = 1'b0, cfg_wr = 1'b0, cfg_pmme = 1'b0;
    logic [1:0]       cfg_cd = 2'b00;
    logic             swb_en = 1'b0, dsp_active = 1'b0;
    logic [N_EVT-1:0] evt = '0;
    logic             core_ce, hf_osc_en, pmm_active, swb_flag;
    logic [1:0]       cur_cd;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #(T_CLK/2) clk = ~clk;

    core_clk_gov #(.N_EVT(N_EVT)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic pm, input logic [1:0] cd);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_pmme = pm; cfg_cd = cd;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_evt(input int idx);
        @(negedge clk);
        evt[idx] = 1'b1;
        @(negedge clk);
        evt = '0;
    endtask

    // Called at the first negedge after a load edge; returns the cycle index of the first pulse.
    task automatic first_ce(output int n);
        n = 1;
        while (!core_ce && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_ce(input int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (core_ce) n++;
        end
    endtask

    task automatic t_reset;
        int n;
        chk("R1 pmm", pmm_active, 0);
        chk("R1 cd", cur_cd, 0);
        chk("R1 flag", swb_flag, 0);
        chk("R1 osc", hf_osc_en, 1);
        count_ce(10, n);
        chk("R1 ce every cycle", n, 10);
    endtask

    task automatic t_full_ratios;
        int n;
        for (int c = 0; c < 4; c++) begin
            wr(1'b0, 2'(c));
            first_ce(n);
            chk("R5 first pulse full", n, 1 << c);
            count_ce(64, n);
            chk("R2 full rate", n, 64 >> c);
        end
    endtask

    task automatic t_pmm_div;
        int n;
        for (int c = 0; c < 3; c++) begin
            wr(1'b1, 2'(c));
            chk("R3 pmm active", pmm_active, 1);
            first_ce(n);
            chk("R3 R5 first pulse 256", n, 256);
            count_ce(512, n);
            chk("R3 rate 256", n, 2);
        end
        wr(1'b0, 2'b00);
    endtask

    task automatic t_pmm_lf;
        int n;
        wr(1'b1, 2'b11);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            lf_tick = (k % 8 == 3);
            #1;
            if (core_ce) n++;
        end
        @(negedge clk);
        lf_tick = 1'b0;
        chk("R4 one per lf strobe", n, 5);
        wr(1'b0, 2'b00);
    endtask

    task automatic t_switchback;
        int n;
        swb_en = 1'b1;
        wr(1'b0, 2'b10);
        wr(1'b1, 2'b00);
        pulse_evt(5);
        chk("R7 back to full", pmm_active, 0);
        chk("R7 restored cd", cur_cd, 2);
        chk("R7 flag", swb_flag, 1);
        first_ce(n);
        chk("R5 first pulse after wake", n, 4);
        // R6: change low-power setting inside PMM, saved code must stay 01
        wr(1'b0, 2'b01);
        wr(1'b1, 2'b00);
        wr(1'b1, 2'b11);
        pulse_evt(0);
        chk("R6 saved code kept", cur_cd, 1);
        chk("R6 full", pmm_active, 0);
        swb_en = 1'b0;
    endtask

    task automatic t_no_wake;
        wr(1'b0, 2'b01);
        wr(1'b1, 2'b00);
        pulse_evt(3);
        chk("R8 disarmed stays pmm", pmm_active, 1);
        chk("R8 disarmed no flag", swb_flag, 0);
        wr(1'b0, 2'b11);
        swb_en = 1'b1;
        pulse_evt(7);
        chk("R8 full ignores cd", cur_cd, 3);
        chk("R8 full ignores flag", swb_flag, 0);
        swb_en = 1'b0;
    endtask

    task automatic t_priority;
        swb_en = 1'b1;
        wr(1'b0, 2'b00);
        wr(1'b1, 2'b00);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_pmme = 1'b1; cfg_cd = 2'b11; evt[2] = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; evt = '0;
        chk("R9 write wins pmm", pmm_active, 1);
        chk("R9 write wins cd", cur_cd, 3);
        chk("R9 no flag", swb_flag, 0);
        swb_en = 1'b0;
    endtask

    task automatic t_flag;
        int n;
        swb_en = 1'b1;
        wr(1'b1, 2'b00);
        pulse_evt(11);
        count_ce(20, n);
        pulse_evt(1);
        chk("R10 flag held", swb_flag, 1);
        wr(1'b0, 2'b00);
        chk("R10 flag cleared by write", swb_flag, 0);
        swb_en = 1'b0;
    endtask

    task automatic t_osc;
        wr(1'b1, 2'b00);
        chk("R11 osc on in div pmm", hf_osc_en, 1);
        wr(1'b1, 2'b11);
        chk("R11 osc off", hf_osc_en, 0);
        dsp_active = 1'b1; #1;
        chk("R11 osc on dsp", hf_osc_en, 1);
        dsp_active = 1'b0; swb_en = 1'b1; #1;
        chk("R11 osc on swb", hf_osc_en, 1);
        swb_en = 1'b0;
        wr(1'b0, 2'b00);
        chk("R11 osc on full", hf_osc_en, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_MAX && !done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, WD_MAX);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_ratios();
        t_pmm_div();
        t_pmm_lf();
        t_switchback();
        t_no_wake();
        t_priority();
        t_flag();
        t_osc();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule